// File: doc/BRIEF.md
# Palette Lookup Table with Sequenced Byte Loading

This block holds a colour palette of up to 256 entries. Each entry has three 4-bit components (red, green and blue). A host loads the table through a byte-wide port that has two registers. The select input picks the index register or the colour register. The host writes an index once. It then writes the colour register three times, in the order red, green, blue. The entry is stored as a whole after the blue write, and the index then steps to the next entry, so a full palette loads as one stream of bytes.

The colour register can also be read back in the same way. Each read returns one component, and every third read moves the index on. Reading the index register returns the current index.

A separate pixel port looks up an index every clock. It returns the 12-bit colour one cycle later, and host activity does not disturb it.

Top module: `pal_lut_wr`

## Requirements
- R1: After reset, every entry is zero, the index is 0, the component phase is red, `host_rdata_o` is 0 and `pix_rgb_o` is 0.
- R2: A write with `host_sel_i`=0 and a value below `NUM_ENTRIES` loads that value as the index and sets the phase to red. A read with `host_sel_i`=0 returns the index, zero-extended, on `host_rdata_o` one cycle later.
- R3: A write with `host_sel_i`=0 and a value at or above `NUM_ENTRIES` is ignored. The index, the phase, any components already written and the table all stay unchanged.
- R4: Writes with `host_sel_i`=1 supply red, then green, then blue. Each write keeps only bits [7:4] of the byte. An entry is packed as red in [11:8], green in [7:4] and blue in [3:0].
- R5: The table entry changes only on the blue write. After one or two colour writes, the pixel port still returns the old entry.
- R6: After the blue write, the index increments and wraps from `NUM_ENTRIES`-1 to 0. The phase returns to red.
- R7: An accepted index write in the middle of a sequence restarts the phase at red. The components written before it are discarded.
- R8: `pix_rgb_o` shows the entry selected by `pix_idx_i` at the previous rising edge. An index at or above `NUM_ENTRIES` reads as 0.
- R9: A read with `host_sel_i`=1 returns the component of the current entry at the current phase in bits [7:4], with bits [3:0] zero, one cycle later. It then advances the phase. After the blue read it advances the index as in R6.
- R10: When `host_we_i` and `host_re_i` are both high, only the write takes effect, and `host_rdata_o` keeps its value. `host_rdata_o` also keeps its value in any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_sel_i | input | 1 | 0: index register, 1: colour register |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, registered |
| pix_idx_i | input | 8 | Pixel lookup index |
| pix_rgb_o | output | 12 | Looked-up colour {r,g,b}, one cycle later |

## Verification
A phase counter that is out of step shows up as rotated components. It appears on the pixel port one cycle after the commit, or on the next colour read-back. A wrong index shows up at once on the next index read. If the index or the wrap is stepped wrongly, the entry lands in the wrong place, and a pixel lookup of either the intended or the struck entry shows the error. An ignored index write that is still accepted, or a staging register that is lost, appears at the next commit.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int BYTE_W = 8;
  localparam int COMP_W = 4;
  localparam int RGB_W  = 3 * COMP_W;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_lut_pkg::*;
#(
  parameter int NUM_ENTRIES = 256,
  parameter int IDX_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output phase_e            phase_o,
  output logic              commit_o,
  output rgb_t              commit_rgb_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0]  idx_q;
  phase_e            phase_q;
  logic [COMP_W-1:0] stage_r_q, stage_g_q;
  logic              idx_ok;
  logic              step;
  logic [IDX_W-1:0]  idx_next;
  logic [COMP_W-1:0] hi_nib;

  assign idx_ok   = int'(wdata_i) < NUM_ENTRIES;
  assign step     = dat_we_i | dat_re_i;
  assign idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  assign hi_nib   = wdata_i[BYTE_W-1 -: COMP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      phase_q   <= PH_RED;
      stage_r_q <= '0;
      stage_g_q <= '0;
    end else if (idx_we_i) begin
      if (idx_ok) begin
        idx_q   <= wdata_i[IDX_W-1:0];
        phase_q <= PH_RED;
      end
    end else if (step) begin
      unique case (phase_q)
        PH_RED: begin
          phase_q <= PH_GRN;
          if (dat_we_i) stage_r_q <= hi_nib;
        end
        PH_GRN: begin
          phase_q <= PH_BLU;
          if (dat_we_i) stage_g_q <= hi_nib;
        end
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_next;
        end
      endcase
    end
  end

  assign idx_o        = idx_q;
  assign phase_o      = phase_q;
  assign commit_o     = dat_we_i && (phase_q == PH_BLU);
  assign commit_rgb_o = '{r: stage_r_q, g: stage_g_q, b: hi_nib};
endmodule

// File: rtl/pal_mem.sv
module pal_mem
  import pal_lut_pkg::*;
#(
  parameter int NUM_ENTRIES = 256,
  parameter int IDX_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  rgb_t              wdata_i,
  input  logic [IDX_W-1:0]  haddr_i,
  output rgb_t              hdata_o,
  input  logic [BYTE_W-1:0] pidx_i,
  output rgb_t              pdata_o
);
  rgb_t ent_q [NUM_ENTRIES];
  rgb_t pdata_q;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[e] <= '0;
      else if (we_i && waddr_i == IDX_W'(e))         ent_q[e] <= wdata_i;
    end
  end

  // host index is always kept in range by the sequencer
  assign hdata_o = ent_q[haddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pdata_q <= '0;
    else if (int'(pidx_i) < NUM_ENTRIES)  pdata_q <= ent_q[pidx_i[IDX_W-1:0]];
    else                                  pdata_q <= '0;
  end

  assign pdata_o = pdata_q;
endmodule

// File: rtl/pal_lut_wr.sv
module pal_lut_wr
  import pal_lut_pkg::*;
#(
  parameter int NUM_ENTRIES = 256,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic              host_sel_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic [BYTE_W-1:0] pix_idx_i,
  output logic [RGB_W-1:0]  pix_rgb_o
);
  logic             rd_go;
  logic [IDX_W-1:0] cur_idx;
  phase_e           cur_phase;
  logic             commit;
  rgb_t             commit_rgb;
  rgb_t             host_ent;
  rgb_t             pix_ent;
  logic [COMP_W-1:0] rd_nib;
  logic [BYTE_W-1:0] rdata_q;

  // write wins over a simultaneous read
  assign rd_go = host_re_i & ~host_we_i;

  pal_seq #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_we_i    (host_we_i & ~host_sel_i),
    .dat_we_i    (host_we_i &  host_sel_i),
    .dat_re_i    (rd_go & host_sel_i),
    .wdata_i     (host_wdata_i),
    .idx_o       (cur_idx),
    .phase_o     (cur_phase),
    .commit_o    (commit),
    .commit_rgb_o(commit_rgb)
  );

  pal_mem #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (commit),
    .waddr_i(cur_idx),
    .wdata_i(commit_rgb),
    .haddr_i(cur_idx),
    .hdata_o(host_ent),
    .pidx_i (pix_idx_i),
    .pdata_o(pix_ent)
  );

  always_comb begin
    unique case (cur_phase)
      PH_RED:  rd_nib = host_ent.r;
      PH_GRN:  rd_nib = host_ent.g;
      default: rd_nib = host_ent.b;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (rd_go)      rdata_q <= host_sel_i ? {rd_nib, {(BYTE_W-COMP_W){1'b0}}}
                                               : BYTE_W'(cur_idx);
  end

  assign host_rdata_o = rdata_q;
  assign pix_rgb_o    = pix_ent;
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int NUM_ENTRIES = 256,
  parameter int IDX_W       = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_we_i,
  input logic             host_re_i,
  input logic             host_sel_i,
  input logic [7:0]       host_wdata_i,
  input logic [7:0]       host_rdata_o,
  input logic [IDX_W-1:0] idx_i,
  input logic [1:0]       phase_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  p_phase_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != 2'd3);

  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !host_sel_i && int'(host_wdata_i) < NUM_ENTRIES)
    |=> (idx_i == IDX_W'($past(host_wdata_i)) && phase_i == 2'd0));

  p_idx_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !host_sel_i && int'(host_wdata_i) >= NUM_ENTRIES)
    |=> ($stable(idx_i) && $stable(phase_i)));

  p_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_sel_i && phase_i == 2'd2)
    |=> (phase_i == 2'd0 &&
         idx_i == (($past(idx_i) == LAST_IDX) ? '0 : $past(idx_i) + 1'b1)));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_re_i || host_we_i) |=> $stable(host_rdata_o));

  p_idx_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && !host_we_i && !host_sel_i) |=> host_rdata_o == 8'($past(idx_i)));
endmodule

bind pal_lut_wr pal_lut_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_we_i   (host_we_i),
  .host_re_i   (host_re_i),
  .host_sel_i  (host_sel_i),
  .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o),
  .idx_i       (cur_idx),
  .phase_i     (cur_phase)
);

// File: tb/pal_lut_wr_test.sv
module pal_lut_wr_test;
  localparam int N = 240;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, sel = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pidx = '0;
  logic [11:0] prgb;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [11:0] ref_mem [N];
  int          ref_idx, ref_ph;
  logic [3:0]  st_r, st_g;

  always #5 clk = ~clk;

  pal_lut_wr #(.NUM_ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_re_i(re),
    .host_sel_i(sel), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .pix_idx_i(pidx), .pix_rgb_o(prgb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] comp_of(input logic [11:0] e, input int ph);
    return (ph == 0) ? e[11:8] : (ph == 1) ? e[7:4] : e[3:0];
  endfunction

  function automatic int nxt(input int i);
    return (i == N - 1) ? 0 : i + 1;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr_idx(input logic [7:0] v);
    we = 1; sel = 0; wdata = v;
    @(negedge clk); we = 0;
    if (int'(v) < N) begin ref_idx = int'(v); ref_ph = 0; end
  endtask

  task automatic wr_dat(input logic [7:0] v);
    we = 1; sel = 1; wdata = v;
    @(negedge clk); we = 0;
    case (ref_ph)
      0: begin st_r = v[7:4]; ref_ph = 1; end
      1: begin st_g = v[7:4]; ref_ph = 2; end
      default: begin
        ref_mem[ref_idx] = {st_r, st_g, v[7:4]};
        ref_ph = 0; ref_idx = nxt(ref_idx);
      end
    endcase
  endtask

  task automatic rd_idx(input string req);
    re = 1; sel = 0;
    @(negedge clk); re = 0;
    chk(rdata == 8'(ref_idx), req, rdata, ref_idx);
  endtask

  task automatic rd_dat(input string req);
    logic [7:0] e;
    e = {comp_of(ref_mem[ref_idx], ref_ph), 4'h0};
    re = 1; sel = 1;
    @(negedge clk); re = 0;
    chk(rdata == e, req, rdata, e);
    if (ref_ph == 2) begin ref_ph = 0; ref_idx = nxt(ref_idx); end
    else ref_ph++;
  endtask

  task automatic pix(input logic [7:0] i, input string req);
    logic [11:0] e;
    e = (int'(i) < N) ? ref_mem[i] : 12'h0;
    pidx = i;
    @(negedge clk);
    chk(prgb == e, req, prgb, e);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold;
    for (int i = 0; i < N; i++) ref_mem[i] = '0;
    ref_idx = 0; ref_ph = 0; st_r = 0; st_g = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(rdata == 8'h0, "R1 rdata", rdata, 0);
    chk(prgb == 12'h0, "R1 pix", prgb, 0);
    rd_idx("R1 index");
    rd_dat("R1 entry0 red");

    // R2 index load and readback
    wr_idx(8'd5);
    rd_idx("R2");
    // R4/R5 sequenced load and atomic commit
    wr_dat(8'hAB); wr_dat(8'hCD);
    pix(8'd5, "R5 partial");
    wr_dat(8'hEF);
    pix(8'd5, "R4 packing");
    chk(prgb == 12'hACE, "R4 value", prgb, 12'hACE);
    rd_idx("R6 increment");

    // R6 wrap at last entry
    wr_idx(8'(N - 1));
    wr_dat(8'h10); wr_dat(8'h20); wr_dat(8'h30);
    rd_idx("R6 wrap");
    pix(8'(N - 1), "R6 last entry");

    // R3 out of range index ignored, phase kept
    wr_idx(8'd10);
    wr_dat(8'h90);
    wr_idx(8'd245);
    rd_idx("R3 index kept");
    wr_dat(8'h50); wr_dat(8'h70);
    pix(8'd10, "R3 phase kept");

    // R7 restart mid-sequence
    wr_idx(8'd20);
    wr_dat(8'hF0); wr_dat(8'hF0);
    wr_idx(8'd20);
    wr_dat(8'h10); wr_dat(8'h20); wr_dat(8'h30);
    pix(8'd20, "R7 restart");
    chk(prgb == 12'h123, "R7 value", prgb, 12'h123);

    // R9 readback sequencing and wrap
    wr_idx(8'd5);
    rd_dat("R9 red"); rd_dat("R9 green"); rd_dat("R9 blue");
    rd_idx("R9 index advance");
    wr_idx(8'(N - 1));
    rd_dat("R9 r"); rd_dat("R9 g"); rd_dat("R9 b");
    rd_idx("R9 wrap");

    // R8 out of range pixel index
    pix(8'd250, "R8 out of range");

    // R10 write wins, rdata holds
    wr_idx(8'd30);
    rd_idx("R10 setup");
    hold = rdata;
    we = 1; re = 1; sel = 1; wdata = 8'h40;
    @(negedge clk); we = 0; re = 0;
    st_r = 4'h4; ref_ph = 1;
    chk(rdata == hold, "R10 hold", rdata, hold);
    @(negedge clk);
    chk(rdata == hold, "R10 idle hold", rdata, hold);
    wr_dat(8'h50); wr_dat(8'h60);
    pix(8'd30, "R10 write took effect");

    // R8 latency: output follows index one edge later
    pidx = 8'd5;
    @(negedge clk);
    pidx = 8'd30;
    chk(prgb == ref_mem[5], "R8 latency", prgb, ref_mem[5]);
    @(negedge clk);
    chk(prgb == ref_mem[30], "R8 next", prgb, ref_mem[30]);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)       wr_idx(8'($urandom_range(0, 255)));
      else if (op < 6)  wr_dat(8'($urandom));
      else if (op < 7)  rd_dat("R9 random");
      else if (op < 8)  rd_idx("R2 random");
      else              pix(8'($urandom_range(0, 255)), "R8 random");
    end
    for (int i = 0; i < N; i += 7) pix(8'(i), "R4 sweep");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule